// File: doc/BRIEF.md
# CAN Bit Destuffer

This block sits between a CAN bit sampler and a frame parser. It receives one sampled bus bit per `in_valid` strobe. It removes the stuff bits that a transmitter inserts after every run of five equal bits. Each real frame bit is passed on with its position in the destuffed frame. Each removed bit is reported on a separate strobe.

The run-length history counts raw bits, so stuff bits are included. A stuff bit can therefore start or extend the run that triggers the next stuff bit. The parser marks the first bit of every frame with `in_sof`. This restarts both the history and the index. The parser drops `stuff_en` for the fixed-form tail of the frame. While it is low, every bit is forwarded untouched and no run error is flagged, but the history keeps counting. If six equal raw bits arrive while detection is on, a one-cycle error flag is raised alongside the forwarded sixth bit. Every output appears one clock after the input strobe and lasts one clock.

Top module: `cdst_destuffer`

## Requirements
- R1: After reset, and again after a reset applied mid-frame, all output strobes are low and the next forwarded bit carries index 0 even without `in_sof`.
- R2: With `stuff_en` high, a bit that differs from the five raw bits before it (last six raw bits 000001 or 111110) pulses `stuff_valid` and does not pulse `data_valid`.
- R3: The run history counts stuff bits. A removed bit followed by four more bits of its own value makes the next differing bit a stuff bit.
- R4: `data_index` starts at 0 on the start-of-frame bit and rises by one for each forwarded bit only. A removed bit leaves the index unchanged.
- R5: A bit strobed with `in_sof` begins a new run of length one. Bits before it never count toward a run.
- R6: With `stuff_en` low, every strobed bit is forwarded and `stuff_error` stays low, while the run history keeps counting those bits.
- R7: With `stuff_en` high, a sixth consecutive equal raw bit is forwarded as a frame bit and pulses `stuff_error` in the same cycle.
- R8: Outputs change only in the clock after an `in_valid` strobe, each strobe lasts one clock, and `data_valid` and `stuff_valid` are never high together.
- R9: `data_bit` equals the bus value of the forwarded input bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | One sampled bus bit is present |
| in_bit | input | 1 | Sampled bus value (0 dominant, 1 recessive) |
| in_sof | input | 1 | Marks the start-of-frame bit; restarts history and index |
| stuff_en | input | 1 | Stuff detection enabled for this bit |
| data_valid | output | 1 | A frame bit is forwarded |
| data_bit | output | 1 | Forwarded frame bit value |
| data_index | output | IDX_W | Destuffed position of the forwarded bit |
| stuff_valid | output | 1 | The strobed bit was removed as a stuff bit |
| stuff_error | output | 1 | Six equal raw bits seen while detection enabled |

## Verification
The assertions assume that `in_sof` only arrives together with `in_valid`. They also assume `in_valid` is a single-cycle strobe per bit, possibly with idle cycles between bits. Their index step checks assume that no frame exceeds 2^IDX_W forwarded bits. The stimulus drives one bit per strobe with an idle gap after each, and raises `in_sof` only with a valid bit. Frames stay under fifty bits, so the index never wraps.

// File: rtl/cdst_pkg.sv
`timescale 1ns/1ps
package cdst_pkg;
  // Classification of one strobed raw bit
  typedef enum logic [1:0] {
    BK_IDLE  = 2'd0,
    BK_FRAME = 2'd1,
    BK_STUFF = 2'd2
  } bit_kind_e;
endpackage

// File: rtl/cdst_run_track.sv
`timescale 1ns/1ps
module cdst_run_track #(
  parameter int RUN_LIMIT = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic smp_valid,
  input  logic smp_bit,
  input  logic smp_first,
  input  logic chk_en,
  output logic stuff_hit,
  output logic six_hit
);
  localparam int RUN_MAX = RUN_LIMIT + 1;
  localparam int RUN_W   = $clog2(RUN_MAX + 1);
  localparam logic [RUN_W-1:0] LIM  = RUN_W'(RUN_LIMIT);
  localparam logic [RUN_W-1:0] SATV = RUN_W'(RUN_MAX);
  localparam logic [RUN_W-1:0] ONE  = RUN_W'(1);

  logic [RUN_W-1:0] run_q;
  logic             hist_q;
  logic             same_c;
  logic             armed_c;

  // Saturating run-length step
  function automatic logic [RUN_W-1:0] run_step(input logic [RUN_W-1:0] r,
                                                input logic same,
                                                input logic first);
    if (first || !same) return ONE;
    if (r >= SATV)      return SATV;
    return r + ONE;
  endfunction

  always_comb begin
    same_c    = (smp_bit == hist_q);
    armed_c   = !smp_first && (run_q >= LIM);
    stuff_hit = smp_valid && chk_en && armed_c && !same_c;
    six_hit   = smp_valid && chk_en && armed_c && same_c;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= '0;
      hist_q <= 1'b0;
    end else if (smp_valid) begin
      run_q  <= run_step(run_q, same_c, smp_first);
      hist_q <= smp_bit;
    end
  end

  assert_run_cap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    run_q <= SATV);
  assert_sof_restart_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && smp_first) |=> (run_q == ONE));
  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_valid |=> $stable(run_q));
endmodule

// File: rtl/cdst_index.sv
`timescale 1ns/1ps
module cdst_index #(
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  input  logic             restart,
  output logic [IDX_W-1:0] cur_idx
);
  logic [IDX_W-1:0] count_q;

  function automatic logic [IDX_W-1:0] idx_next(input logic [IDX_W-1:0] c);
    return c + IDX_W'(1);
  endfunction

  assign cur_idx = restart ? '0 : count_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       count_q <= '0;
    else if (adv)     count_q <= idx_next(cur_idx);
    else if (restart) count_q <= '0;
  end

  assert_idx_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !restart) |=> (count_q == $past(count_q) + IDX_W'(1)));
  assert_idx_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv && !restart) |=> $stable(count_q));
  assert_idx_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && restart) |=> (count_q == IDX_W'(1)));
endmodule

// File: rtl/cdst_destuffer.sv
`timescale 1ns/1ps
module cdst_destuffer #(
  parameter int IDX_W     = 8,
  parameter int RUN_LIMIT = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             in_bit,
  input  logic             in_sof,
  input  logic             stuff_en,
  output logic             data_valid,
  output logic             data_bit,
  output logic [IDX_W-1:0] data_index,
  output logic             stuff_valid,
  output logic             stuff_error
);
  import cdst_pkg::*;

  logic             stuff_hit_w;
  logic             six_hit_w;
  logic             fwd_w;
  logic             restart_w;
  logic [IDX_W-1:0] idx_w;
  bit_kind_e        kind_w;

  assign restart_w = in_valid && in_sof;

  cdst_run_track #(.RUN_LIMIT(RUN_LIMIT)) u_run (
    .clk       (clk),
    .rst_n     (rst_n),
    .smp_valid (in_valid),
    .smp_bit   (in_bit),
    .smp_first (in_sof),
    .chk_en    (stuff_en),
    .stuff_hit (stuff_hit_w),
    .six_hit   (six_hit_w)
  );

  always_comb begin
    if (!in_valid)        kind_w = BK_IDLE;
    else if (stuff_hit_w) kind_w = BK_STUFF;
    else                  kind_w = BK_FRAME;
  end

  assign fwd_w = (kind_w == BK_FRAME);

  cdst_index #(.IDX_W(IDX_W)) u_idx (
    .clk     (clk),
    .rst_n   (rst_n),
    .adv     (fwd_w),
    .restart (restart_w),
    .cur_idx (idx_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_valid  <= 1'b0;
      data_bit    <= 1'b0;
      data_index  <= '0;
      stuff_valid <= 1'b0;
      stuff_error <= 1'b0;
    end else begin
      data_valid  <= fwd_w;
      stuff_valid <= (kind_w == BK_STUFF);
      stuff_error <= six_hit_w;
      if (fwd_w) begin
        data_bit   <= in_bit;
        data_index <= idx_w;
      end
    end
  end

  assert_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(data_valid && stuff_valid));
  assert_strobe_src_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (data_valid || stuff_valid) |-> $past(in_valid));
  assert_err_en_R6: assert property (@(posedge clk) disable iff (!rst_n)
    stuff_error |-> $past(stuff_en));
  assert_err_fwd_R7: assert property (@(posedge clk) disable iff (!rst_n)
    stuff_error |-> data_valid);
  assert_sof_nostuff_R5: assert property (@(posedge clk) disable iff (!rst_n)
    stuff_valid |-> !$past(in_sof));
  assert_bit_R9: assert property (@(posedge clk) disable iff (!rst_n)
    data_valid |-> (data_bit == $past(in_bit)));
endmodule

// File: tb/test_cdst_destuffer.sv
`timescale 1ns/1ps
module test_cdst_destuffer;
  localparam int IDX_W = 8;
  localparam int NV    = 42;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             in_valid = 1'b0;
  logic             in_bit = 1'b0;
  logic             in_sof = 1'b0;
  logic             stuff_en = 1'b1;
  logic             data_valid;
  logic             data_bit;
  logic [IDX_W-1:0] data_index;
  logic             stuff_valid;
  logic             stuff_error;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  cdst_destuffer #(.IDX_W(IDX_W), .RUN_LIMIT(5)) i_cdst_destuffer (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_bit(in_bit),
    .in_sof(in_sof), .stuff_en(stuff_en), .data_valid(data_valid),
    .data_bit(data_bit), .data_index(data_index),
    .stuff_valid(stuff_valid), .stuff_error(stuff_error)
  );

  // Vector: {bit, sof, en, exp_stuff, exp_err, exp_idx[7:0]}
  localparam logic [12:0] VEC [NV] = '{
    {5'b01100, 8'd0},  {5'b00100, 8'd1},  {5'b00100, 8'd2},  {5'b00100, 8'd3},
    {5'b00100, 8'd4},  {5'b10110, 8'd0},  {5'b10100, 8'd5},  {5'b10100, 8'd6},
    {5'b10100, 8'd7},  {5'b10100, 8'd8},  {5'b00110, 8'd0},  {5'b00100, 8'd9},
    {5'b10100, 8'd10}, {5'b10100, 8'd11}, {5'b10100, 8'd12}, {5'b10100, 8'd13},
    {5'b10100, 8'd14}, {5'b00000, 8'd15}, {5'b00000, 8'd16}, {5'b11100, 8'd0},
    {5'b10100, 8'd1},  {5'b10100, 8'd2},  {5'b10100, 8'd3},  {5'b10100, 8'd4},
    {5'b10101, 8'd5},  {5'b00110, 8'd0},  {5'b00100, 8'd6},  {5'b00100, 8'd7},
    {5'b00100, 8'd8},  {5'b01100, 8'd0},  {5'b00100, 8'd1},  {5'b00100, 8'd2},
    {5'b00100, 8'd3},  {5'b00100, 8'd4},  {5'b10110, 8'd0},  {5'b10100, 8'd5},
    {5'b10100, 8'd6},  {5'b10100, 8'd7},  {5'b10100, 8'd8},  {5'b10000, 8'd9},
    {5'b00110, 8'd0},  {5'b00100, 8'd10}
  };

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic send(input logic b, input logic s, input logic e);
    @(negedge clk);
    in_valid = 1'b1; in_bit = b; in_sof = s; stuff_en = e;
    @(posedge clk);
    #1;
    in_valid = 1'b0; in_sof = 1'b0;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL R8 watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    check("R1", "data_valid at reset", data_valid, 0);
    check("R1", "stuff_valid at reset", stuff_valid, 0);
    check("R1", "stuff_error at reset", stuff_error, 0);
    @(negedge clk); rst_n = 1'b1;

    for (int k = 0; k < NV; k++) begin
      logic       vb, vs, ve, xs, xe;
      logic [7:0] xi;
      {vb, vs, ve, xs, xe, xi} = VEC[k];
      send(vb, vs, ve);
      // R2 R3 R5 R6: stuff classification; R8 exclusivity
      check(xs ? "R2" : "R8", $sformatf("stuff_valid v%0d", k), stuff_valid, xs);
      check(ve ? "R2" : "R6", $sformatf("data_valid v%0d", k), data_valid, !xs);
      check(xe ? "R7" : "R6", $sformatf("stuff_error v%0d", k), stuff_error, xe);
      if (!xs) begin
        check("R4", $sformatf("data_index v%0d", k), data_index, xi);
        check("R9", $sformatf("data_bit v%0d", k), data_bit, vb);
      end
    end

    // R8: pulses last one clock and nothing follows an idle cycle
    @(posedge clk); #1;
    check("R8", "data_valid idle", data_valid, 0);
    check("R8", "stuff_valid idle", stuff_valid, 0);
    check("R8", "stuff_error idle", stuff_error, 0);

    // R1: reset mid-frame, then bits without sof restart at index 0
    send(1'b0, 1'b1, 1'b1);
    send(1'b0, 1'b0, 1'b1);
    send(1'b0, 1'b0, 1'b1);
    @(negedge clk); rst_n = 1'b0;
    @(posedge clk); #1;
    check("R1", "data_valid in mid reset", data_valid, 0);
    @(negedge clk); rst_n = 1'b1;
    send(1'b0, 1'b0, 1'b1);
    check("R1", "index after mid reset", data_index, 0);
    check("R1", "data_valid after mid reset", data_valid, 1);
    send(1'b0, 1'b0, 1'b1);
    send(1'b0, 1'b0, 1'b1);
    // R5: history cleared by reset, so three earlier zeros do not count
    check("R5", "no error after reset history", stuff_error, 0);
    send(1'b1, 1'b0, 1'b1);
    check("R2", "no stuff on short run", stuff_valid, 0);
    check("R4", "index continues", data_index, 3);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule